// File: doc/BRIEF.md
# Serial Flash Command Header Decoder

This block is the receive front end of a page-organized serial flash target. It watches a select-framed serial stream clocked by SCK, shifts in the first 32 bits of each frame most significant bit first, and reads them as an 8-bit command code followed by a 24-bit address field. When the last header bit arrives it registers the command code and two address outputs, and raises a one-cycle completion strobe.

The address field can be read in two ways, chosen by a page-size mode input. Standard mode serves 528-byte pages: the byte index takes the low 10 bits and the page number takes the 13 bits above them. Binary mode serves 512-byte pages: the byte index takes the low 9 bits and the page number takes the 13 bits above those. Any address bits above the page field are dummy bits and are dropped. The byte output also serves as the buffer byte address for commands that target a buffer. A frame whose select rises before the header is complete is flagged as a framing error.

Top module: `sflash_hdr_dec`

## Requirements
- R1: After reset the command output, page output and byte output are zero, and both the strobe and the error flag are low.
- R2: The command output holds the first 8 bits of the frame, with the first bit received as bit 7.
- R3: The strobe is high for exactly one SCK cycle, the cycle after the rising edge that samples the 32nd bit of a frame. All header outputs hold their new values in that same cycle.
- R4: In standard mode (mode input 0), page = address[22:10] and byte = address[9:0], where address bit 23 is the first address bit received. Address bit 23 has no effect.
- R5: In binary mode (mode input 1), page = address[21:9], byte bit 9 = 0 and byte[8:0] = address[8:0]. Address bits 23 and 22 have no effect.
- R6: The mode is taken from the first SCK edge of a frame. Changing it later in that frame has no effect on that frame's decode.
- R7: Bits after the 32nd in a frame change none of the outputs and cause no further strobe.
- R8: If select is sampled high after a frame of fewer than 32 bits, the error flag goes high on that edge. It stays high until the first edge of the next frame. No strobe is produced and the previous header outputs are kept.
- R9: Between strobes the command, page and byte outputs do not change.
- R10: Every frame starts its bit count from zero, whatever happened in the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Serial clock. All inputs are sampled on its rising edge. |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low frame select |
| si_i | input | 1 | Serial data in, most significant bit first |
| binary_mode_i | input | 1 | Page-size mode: 0 = 528-byte pages, 1 = 512-byte pages |
| opcode_o | output | 8 | Command code of the last complete header |
| page_o | output | 13 | Decoded page address |
| byte_o | output | 10 | Byte-in-page or buffer byte address |
| hdr_valid_o | output | 1 | One-cycle header-complete strobe |
| frame_err_o | output | 1 | Set by a frame that ends early |

## Verification
The assertions assume that SCK runs continuously, also while select is high. They also assume that select, serial data and mode change only away from the rising SCK edge, and that reset is asserted before the first frame. The bench drives every input on the falling edge of SCK and keeps SCK running between frames, so each rising edge sees settled values. Its frames cover full headers in both modes, dummy bits set, a mode flip inside a frame, trailing data bits, and short frames of several lengths. All of these stay within those assumptions.

// File: rtl/sflash_hdr_pkg.sv
package sflash_hdr_pkg;
  localparam int OP_W       = 8;
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int PAGE_W     = 13;
  localparam int STD_BYTE_W = 10;
  localparam int BIN_BYTE_W = 9;

  typedef enum logic {
    PG_STD = 1'b0,
    PG_BIN = 1'b1
  } pg_mode_e;
endpackage

// File: rtl/sflash_hdr_shift.sv
module sflash_hdr_shift #(
  parameter int HDR_W = 32,
  localparam int CNT_W = $clog2(HDR_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             si_i,
  output logic             start_o,
  output logic             done_o,
  output logic             short_end_o,
  output logic [HDR_W-1:0] word_o
);
  logic             cs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic [HDR_W-2:0] sh_q;

  assign start_o     = !cs_ni && cs_q;
  assign cnt_eff     = start_o ? '0 : cnt_q;
  assign done_o      = !cs_ni && (cnt_eff == CNT_W'(HDR_W - 1));
  assign short_end_o = cs_ni && !cs_q && (cnt_q != CNT_W'(HDR_W));
  assign word_o      = {sh_q, si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cs_q <= cs_ni;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (cnt_eff != CNT_W'(HDR_W)) begin
        // saturate at HDR_W so trailing data leaves the header alone
        cnt_q <= cnt_eff + CNT_W'(1);
        sh_q  <= word_o[HDR_W-2:0];
      end
    end
  end
endmodule

// File: rtl/sflash_hdr_split.sv
module sflash_hdr_split #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_W     = 13,
  parameter int STD_BYTE_W = 10,
  parameter int BIN_BYTE_W = 9
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  bin_i,
  output logic [PAGE_W-1:0]     page_o,
  output logic [STD_BYTE_W-1:0] byte_o
);
  localparam int USED_W = PAGE_W + STD_BYTE_W;

  generate
    if (USED_W < ADDR_W) begin : g_dummy
      logic unused_dummy;
      assign unused_dummy = ^addr_i[ADDR_W-1:USED_W];
    end
  endgenerate

  always_comb begin
    if (bin_i) begin
      page_o = addr_i[BIN_BYTE_W +: PAGE_W];
      byte_o = STD_BYTE_W'(addr_i[BIN_BYTE_W-1:0]);
    end else begin
      page_o = addr_i[STD_BYTE_W +: PAGE_W];
      byte_o = addr_i[STD_BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/sflash_hdr_dec.sv
module sflash_hdr_dec
  import sflash_hdr_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int AW   = ADDR_W,
  parameter int PGW  = PAGE_W,
  parameter int SBW  = STD_BYTE_W,
  parameter int BBW  = BIN_BYTE_W,
  localparam int HW  = OPW + AW
) (
  input  logic           sck_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           si_i,
  input  logic           binary_mode_i,
  output logic [OPW-1:0] opcode_o,
  output logic [PGW-1:0] page_o,
  output logic [SBW-1:0] byte_o,
  output logic           hdr_valid_o,
  output logic           frame_err_o
);
  logic           start;
  logic           done;
  logic           short_end;
  logic [HW-1:0]  word;
  pg_mode_e       mode_q;
  logic           bin_eff;
  logic [PGW-1:0] page_d;
  logic [SBW-1:0] byte_d;

  sflash_hdr_shift #(.HDR_W(HW)) u_shift (
    .clk_i      (sck_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .si_i       (si_i),
    .start_o    (start),
    .done_o     (done),
    .short_end_o(short_end),
    .word_o     (word)
  );

  // mode is frozen on the first edge of the frame
  assign bin_eff = start ? binary_mode_i : (mode_q == PG_BIN);

  sflash_hdr_split #(
    .ADDR_W    (AW),
    .PAGE_W    (PGW),
    .STD_BYTE_W(SBW),
    .BIN_BYTE_W(BBW)
  ) u_split (
    .addr_i(word[AW-1:0]),
    .bin_i (bin_eff),
    .page_o(page_d),
    .byte_o(byte_d)
  );

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= PG_STD;
      opcode_o    <= '0;
      page_o      <= '0;
      byte_o      <= '0;
      hdr_valid_o <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      hdr_valid_o <= done;
      if (start) mode_q <= pg_mode_e'(binary_mode_i);
      if (done) begin
        opcode_o <= word[HW-1 -: OPW];
        page_o   <= page_d;
        byte_o   <= byte_d;
      end
      if (start)          frame_err_o <= 1'b0;
      else if (short_end) frame_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sflash_hdr_chk.sv
module sflash_hdr_chk #(
  parameter int OPW = 8,
  parameter int PGW = 13,
  parameter int SBW = 10
) (
  input logic           sck_i,
  input logic           rst_ni,
  input logic           cs_ni,
  input logic           mode_bin_i,
  input logic [OPW-1:0] opcode_o,
  input logic [PGW-1:0] page_o,
  input logic [SBW-1:0] byte_o,
  input logic           hdr_valid_o,
  input logic           frame_err_o
);
  a_r3_single_pulse: assert property (@(posedge sck_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o);

  a_r3_no_pulse_after_idle: assert property (@(posedge sck_i) disable iff (!rst_ni)
    cs_ni |=> !hdr_valid_o);

  a_r8_err_excludes_pulse: assert property (@(posedge sck_i) disable iff (!rst_ni)
    frame_err_o |-> !hdr_valid_o);

  a_r8_err_set_only_at_end: assert property (@(posedge sck_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> cs_ni);

  a_r9_opcode_hold: assert property (@(posedge sck_i) disable iff (!rst_ni)
    !hdr_valid_o |-> $stable(opcode_o));

  a_r9_addr_hold: assert property (@(posedge sck_i) disable iff (!rst_ni)
    !hdr_valid_o |-> ($stable(page_o) && $stable(byte_o)));

  a_r5_bin_byte_top: assert property (@(posedge sck_i) disable iff (!rst_ni)
    (hdr_valid_o && mode_bin_i) |-> !byte_o[SBW-1]);
endmodule

bind sflash_hdr_dec sflash_hdr_chk #(.OPW(OPW), .PGW(PGW), .SBW(SBW)) u_chk (
  .sck_i      (sck_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .mode_bin_i (mode_q == sflash_hdr_pkg::PG_BIN),
  .opcode_o   (opcode_o),
  .page_o     (page_o),
  .byte_o     (byte_o),
  .hdr_valid_o(hdr_valid_o),
  .frame_err_o(frame_err_o)
);

// File: tb/tb_sflash_hdr_dec.sv
module tb_sflash_hdr_dec;
  localparam time CLK_PERIOD = 10ns;

  logic       sck = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       si = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] opcode;
  logic [12:0] page;
  logic [9:0] byte_a;
  logic       hdr_valid;
  logic       frame_err;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) sck = ~sck;

  sflash_hdr_dec dut (
    .sck_i(sck), .rst_ni(rst_n), .cs_ni(cs_n), .si_i(si),
    .binary_mode_i(mode), .opcode_o(opcode), .page_o(page),
    .byte_o(byte_a), .hdr_valid_o(hdr_valid), .frame_err_o(frame_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int          m_cnt = 0;
  bit          m_prev_cs = 1;
  bit          m_bin = 0;
  bit          m_hdr_bin = 0;
  bit [31:0]   m_acc = 0;
  logic [7:0]  e_op = 0;
  logic [12:0] e_page = 0;
  logic [9:0]  e_byte = 0;
  logic        e_valid = 0;
  logic        e_err = 0;

  always @(posedge sck) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev_cs = 1; m_acc = 0;
      e_op = 0; e_page = 0; e_byte = 0; e_valid = 0; e_err = 0;
    end else begin
      e_valid = 0;
      if (cs_n) begin
        if (!m_prev_cs && m_cnt < 32) e_err = 1;
        m_cnt = 0;
      end else begin
        if (m_prev_cs) begin
          m_cnt = 0; m_bin = mode; e_err = 0;
        end
        if (m_cnt < 32) begin
          m_acc = {m_acc[30:0], si};
          m_cnt++;
          if (m_cnt == 32) begin
            e_valid = 1;
            e_op = m_acc[31:24];
            m_hdr_bin = m_bin;
            if (m_bin) begin
              e_page = m_acc[21:9];
              e_byte = {1'b0, m_acc[8:0]};
            end else begin
              e_page = m_acc[22:10];
              e_byte = m_acc[9:0];
            end
          end
        end
      end
      m_prev_cs = cs_n;
    end
  end

  always @(negedge sck) begin
    if (rst_n && !finished) begin
      if (hdr_valid) pulses++;
      chk("R2 opcode", opcode, e_op);
      chk(m_hdr_bin ? "R5 page" : "R4 page", page, e_page);
      chk(m_hdr_bin ? "R5 byte" : "R4 byte", byte_a, e_byte);
      chk("R3 strobe", hdr_valid, e_valid);
      chk("R8 error", frame_err, e_err);
    end
  end

  // nbits: bits sent; flip_at: bit index where mode inverts (-1 none)
  task automatic frame(input [7:0] op, input [23:0] a, input bit bin,
                       input int nbits, input int flip_at);
    logic [31:0] hdr;
    hdr = {op, a};
    pulses = 0;
    @(negedge sck);
    cs_n = 0;
    mode = bin;
    for (int i = 0; i < nbits; i++) begin
      si = (i < 32) ? hdr[31 - i] : i[0];
      if (i == flip_at) mode = ~bin;
      @(negedge sck);
    end
    cs_n = 1;
    mode = bin;
    si = 0;
    repeat (2) @(negedge sck);
  endtask

  initial begin
    repeat (20000) @(posedge sck);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    repeat (3) @(negedge sck);
    // R1 reset state
    chk("R1 opcode", opcode, 0);
    chk("R1 page", page, 0);
    chk("R1 byte", byte_a, 0);
    chk("R1 strobe", hdr_valid, 0);
    chk("R1 error", frame_err, 0);
    rst_n = 1;
    repeat (2) @(negedge sck);

    // R4 standard split, R2 opcode
    a = 24'hABCDEF;
    frame(8'h9A, a, 0, 32, -1);
    chk("R2 opcode", opcode, 8'h9A);
    chk("R4 page", page, a[22:10]);
    chk("R4 byte", byte_a, a[9:0]);
    chk("R3 one pulse", pulses, 1);

    // R5 binary split, dummy bits 23:22 set
    a = 24'hC12345;
    frame(8'h3C, a, 1, 32, -1);
    chk("R5 page", page, a[21:9]);
    chk("R5 byte", byte_a, {1'b0, a[8:0]});

    // R4 addr bit 23 ignored
    frame(8'h55, 24'h800000, 0, 32, -1);
    chk("R4 dummy page", page, 0);
    chk("R4 dummy byte", byte_a, 0);

    // R6 mode flip mid-frame
    a = 24'h3FFFFF;
    frame(8'hE8, a, 0, 32, 5);
    chk("R6 page", page, a[22:10]);
    chk("R6 byte", byte_a, a[9:0]);
    frame(8'hE9, a, 1, 32, 20);
    chk("R6 bin byte", byte_a, {1'b0, a[8:0]});

    // R7 trailing data bits
    a = 24'h012345;
    frame(8'h0B, a, 0, 64, -1);
    chk("R7 opcode", opcode, 8'h0B);
    chk("R7 page", page, a[22:10]);
    chk("R7 byte", byte_a, a[9:0]);
    chk("R7 one pulse", pulses, 1);

    // R8 short frame keeps previous header
    frame(8'hFF, 24'hFFFFFF, 1, 20, -1);
    chk("R8 error set", frame_err, 1);
    chk("R8 no pulse", pulses, 0);
    chk("R9 opcode kept", opcode, 8'h0B);
    chk("R9 byte kept", byte_a, a[9:0]);
    frame(8'hAA, 24'h000000, 0, 1, -1);
    chk("R8 one-bit error", frame_err, 1);
    frame(8'hAA, 24'h000000, 0, 31, -1);
    chk("R8 31-bit error", frame_err, 1);

    // R10 full frame after short ones counts from zero; error clears
    a = 24'h5A5A5A;
    frame(8'h77, a, 1, 32, -1);
    chk("R10 opcode", opcode, 8'h77);
    chk("R10 page", page, a[21:9]);
    chk("R8 error cleared", frame_err, 0);
    chk("R10 one pulse", pulses, 1);

    // R8 again after a successful header
    frame(8'h12, 24'h000001, 0, 8, -1);
    chk("R8 error after good", frame_err, 1);
    chk("R9 page kept", page, a[21:9]);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule